// File: doc/BRIEF.md
# Mixed-Width SPI Data FIFO Pair

This block holds the data path between a host register interface and a byte-serial SPI shifter. It has two byte-granular queues of 32 entries each: a transmit queue that the host fills and the shifter drains, and a receive queue that the shifter fills and the host drains. The shifter side always moves one byte per cycle. On each host access, a single select input chooses whether one byte or four bytes move.

Four-byte accesses are big-endian. The most significant byte of the 32-bit word is the first byte queued, or the first byte dequeued. An access that needs more room, or more data, than the queue can supply is refused as a whole. A refused access leaves the queue unchanged and raises an error flag for one cycle. Each queue reports its level as a 6-bit value so that all 32 entries can be shown. The transmit side reports free bytes and the receive side reports held bytes. Each queue also has full and empty flags for the event logic. A flush input empties both queues in a single cycle.

Top module: `mixw_spi_fifo`

## Requirements
- R1: After reset, `tx_free` is 32, `rx_count` is 0, `tx_empty` and `rx_empty` are 1, `tx_full` and `rx_full` are 0, and both error flags are 0.
- R2: A host transmit push with `tx_host_wide`=1 queues four bytes in the order bits 31:24, 23:16, 15:8, 7:0. The SPI side then reads them one per pop on `tx_spi_data`, which shows the head byte.
- R3: A host transmit push with `tx_host_wide`=0 queues only `tx_host_data[7:0]`. Bits 31:8 are ignored.
- R4: An accepted receive pop drives `rx_host_data` in the same cycle. A word pop returns the oldest byte in bits 31:24 and the next three bytes below it. A byte pop returns the oldest byte in bits 7:0, with bits 31:8 at zero.
- R5: `tx_free` equals 32 minus the bytes held in the transmit queue, and `rx_count` equals the bytes held in the receive queue. Both update on the clock edge that ends the access. Each full flag is 1 exactly when the queue holds 32 bytes, and each empty flag is 1 exactly when it holds 0 bytes.
- R6: A transmit push that needs more space than `tx_free` is refused. A word push needs 4 free bytes and a byte push needs 1. A refused push leaves the queue unchanged, and `tx_err` is 1 during the single cycle after it.
- R7: A receive word pop with fewer than 4 bytes held is refused. It returns zero on `rx_host_data`, leaves the queue unchanged, and `rx_err` is 1 during the single cycle after it.
- R8: A receive byte pop on an empty queue returns zero, leaves the queue unchanged, and does not raise `rx_err`.
- R9: When a host push and an SPI pop hit the transmit queue in the same cycle, or an SPI push and a host pop hit the receive queue in the same cycle, the level changes by exactly the number of bytes written minus the number read. Acceptance of each access is judged on the level before that cycle.
- R10: A cycle with `flush`=1 leaves both queues empty after the clock edge and both error flags at 0. Every push and pop presented in that cycle is ignored.
- R11: An SPI push into a full receive queue is dropped and the level stays at 32. An SPI pop from an empty transmit queue changes nothing, and `tx_spi_data` reads 0 while that queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty both queues this cycle |
| tx_host_push | input | 1 | Host writes to the transmit queue |
| tx_host_wide | input | 1 | 1 = four-byte push, 0 = single-byte push |
| tx_host_data | input | 32 | Push data, big-endian for word pushes, bits 7:0 for byte pushes |
| tx_spi_pop | input | 1 | Shifter takes one byte from the transmit queue |
| tx_spi_data | output | 8 | Head byte of the transmit queue, 0 when empty |
| tx_free | output | 6 | Free bytes in the transmit queue |
| tx_full | output | 1 | Transmit queue holds 32 bytes |
| tx_empty | output | 1 | Transmit queue holds no bytes |
| tx_err | output | 1 | A transmit push was refused in the previous cycle |
| rx_spi_push | input | 1 | Shifter deposits one byte into the receive queue |
| rx_spi_data | input | 8 | Byte from the shifter |
| rx_host_pop | input | 1 | Host reads from the receive queue |
| rx_host_wide | input | 1 | 1 = four-byte pop, 0 = single-byte pop |
| rx_host_data | output | 32 | Pop data, valid in the cycle of an accepted pop, otherwise 0 |
| rx_count | output | 6 | Bytes held in the receive queue |
| rx_full | output | 1 | Receive queue holds 32 bytes |
| rx_empty | output | 1 | Receive queue holds no bytes |
| rx_err | output | 1 | A receive word pop was refused in the previous cycle |

## Verification
Every cycle, the checker confirms the following. Both levels stay within 32. A same-cycle single-byte push and pop on the transmit queue leaves its level unchanged. A flush is always followed by empty queues and clear error flags. A word push into fewer than four free bytes raises the transmit error. A pop on an empty receive queue never returns non-zero data. A full receive queue stays full when the shifter pushes with no host pop. Byte order is different: the big-endian ordering of word accesses, the masking of the upper bits on byte pushes, and the exact level after a mixed sequence of pushes and pops can only be shown by the directed scenarios, which compare the data stream against values computed in the bench.

// File: rtl/mixw_fifo_pkg.sv
// Package: shared sizing helpers for the mixed-width SPI FIFO pair.
// Assumes queue depths are powers of two so pointers wrap naturally.
package mixw_fifo_pkg;

    // Bytes moved by one wide host access.
    localparam int unsigned LANES = 4;

    // Width of a per-access byte-count field able to hold 0..LANES.
    localparam int unsigned LEN_W = $clog2(LANES + 1);

    // Host access size selector.
    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_WORD = 1'b1
    } acc_size_e;

endpackage

// File: rtl/mixw_access_gate.sv
// Module: decides whether one access of one or LANES bytes may proceed,
// given the bytes available on that side (free space or held data).
// Assumes level never exceeds the queue depth. A refused byte access is
// reported only when REPORT_BYTE is set; refused wide accesses always are.
module mixw_access_gate
    import mixw_fifo_pkg::*;
#(
    parameter int unsigned CNT_W       = 6,
    parameter bit          REPORT_BYTE = 1'b1
) (
    input  logic             req,
    input  acc_size_e        size,
    input  logic [CNT_W-1:0] level,
    output logic [LEN_W-1:0] len,
    output logic             granted,
    output logic             reject
);

    logic [CNT_W-1:0] need;

    // Compute the byte count the access requires and judge it against level.
    always_comb begin
        need    = (size == ACC_WORD) ? CNT_W'(LANES) : CNT_W'(1);
        granted = req && (level >= need);
        len     = granted ? LEN_W'(need) : '0;
        reject  = req && !granted && ((size == ACC_WORD) || REPORT_BYTE);
    end

endmodule

// File: rtl/mixw_byte_queue.sv
// Module: byte-wide circular queue that writes and reads up to LANES bytes
// per cycle. Byte k of the incoming word sits at bits [8*LANES-1-8k -: 8];
// the peek word presents the oldest byte in the top lane likewise.
// Assumes DEPTH is a power of two and that callers never ask for more
// bytes than are free (write) or held (read) - the gates guarantee that.
module mixw_byte_queue
    import mixw_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CNT_W = AW + 1,
    localparam int unsigned DW    = 8 * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [DW-1:0]    wr_word,
    input  logic [LEN_W-1:0] rd_len,
    output logic [DW-1:0]    peek,
    output logic [CNT_W-1:0] count
);

    logic [7:0]       store [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CNT_W-1:0] held;

    // Store the accepted bytes, lane 0 (top byte) at the write pointer.
    always_ff @(posedge clk) begin
        for (int k = 0; k < int'(LANES); k++) begin
            if (LEN_W'(k) < wr_len) begin
                store[wr_ptr + AW'(k)] <= wr_word[DW-1-8*k -: 8];
            end
        end
    end

    // Advance pointers and keep the exact byte count across mixed accesses.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            held   <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(wr_len);
            rd_ptr <= rd_ptr + AW'(rd_len);
            held   <= held + CNT_W'(wr_len) - CNT_W'(rd_len);
        end
    end

    // Present the oldest LANES bytes, oldest in the top lane.
    for (genvar k = 0; k < int'(LANES); k++) begin : g_peek
        assign peek[DW-1-8*k -: 8] = store[rd_ptr + AW'(k)];
    end

    assign count = held;

endmodule

// File: rtl/mixw_spi_fifo.sv
// Module: transmit and receive byte queues between a host data register
// (one or four bytes per access, big-endian) and a byte-serial SPI side.
// Assumes the host and shifter share clk; flush dominates every access.
// Error flags pulse for the one cycle after a refused access.
module mixw_spi_fifo
    import mixw_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1,
    localparam int unsigned DW    = 8 * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             tx_host_push,
    input  logic             tx_host_wide,
    input  logic [DW-1:0]    tx_host_data,
    input  logic             tx_spi_pop,
    output logic [7:0]       tx_spi_data,
    output logic [CNT_W-1:0] tx_free,
    output logic             tx_full,
    output logic             tx_empty,
    output logic             tx_err,
    input  logic             rx_spi_push,
    input  logic [7:0]       rx_spi_data,
    input  logic             rx_host_pop,
    input  logic             rx_host_wide,
    output logic [DW-1:0]    rx_host_data,
    output logic [CNT_W-1:0] rx_count,
    output logic             rx_full,
    output logic             rx_empty,
    output logic             rx_err
);

    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] tx_held;
    logic [LEN_W-1:0] tx_wr_len, tx_rd_len, rx_wr_len, rx_rd_len;
    logic             tx_host_ok, tx_host_rej, tx_spi_ok, tx_spi_rej;
    logic             rx_spi_ok, rx_spi_rej, rx_host_ok, rx_host_rej;
    logic [DW-1:0]    tx_wr_word, tx_peek, rx_wr_word, rx_peek;
    logic [CNT_W-1:0] rx_room;
    acc_size_e        tx_size, rx_size;

    // Map the width selects onto the shared access-size type.
    assign tx_size = tx_host_wide ? ACC_WORD : ACC_BYTE;
    assign rx_size = rx_host_wide ? ACC_WORD : ACC_BYTE;

    // ---------------- transmit side ----------------
    mixw_access_gate #(.CNT_W(CNT_W), .REPORT_BYTE(1'b1)) i_tx_host_gate (
        .req     (tx_host_push && !flush),
        .size    (tx_size),
        .level   (tx_free),
        .len     (tx_wr_len),
        .granted (tx_host_ok),
        .reject  (tx_host_rej)
    );

    mixw_access_gate #(.CNT_W(CNT_W), .REPORT_BYTE(1'b0)) i_tx_spi_gate (
        .req     (tx_spi_pop && !flush),
        .size    (ACC_BYTE),
        .level   (tx_held),
        .len     (tx_rd_len),
        .granted (tx_spi_ok),
        .reject  (tx_spi_rej)
    );

    // Align a byte push into the top lane so it is the one byte stored.
    assign tx_wr_word = tx_host_wide ? tx_host_data
                                     : {tx_host_data[7:0], {(DW-8){1'b0}}};

    mixw_byte_queue #(.DEPTH(DEPTH)) i_tx_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (flush),
        .wr_len  (tx_wr_len),
        .wr_word (tx_wr_word),
        .rd_len  (tx_rd_len),
        .peek    (tx_peek),
        .count   (tx_held)
    );

    // Report free space and flags; head byte reads zero when empty.
    always_comb begin
        tx_free     = FULL_LVL - tx_held;
        tx_full     = (tx_held == FULL_LVL);
        tx_empty    = (tx_held == '0);
        tx_spi_data = tx_empty ? 8'h00 : tx_peek[DW-1 -: 8];
    end

    // ---------------- receive side ----------------
    assign rx_room = FULL_LVL - rx_count;

    mixw_access_gate #(.CNT_W(CNT_W), .REPORT_BYTE(1'b0)) i_rx_spi_gate (
        .req     (rx_spi_push && !flush),
        .size    (ACC_BYTE),
        .level   (rx_room),
        .len     (rx_wr_len),
        .granted (rx_spi_ok),
        .reject  (rx_spi_rej)
    );

    mixw_access_gate #(.CNT_W(CNT_W), .REPORT_BYTE(1'b0)) i_rx_host_gate (
        .req     (rx_host_pop && !flush),
        .size    (rx_size),
        .level   (rx_count),
        .len     (rx_rd_len),
        .granted (rx_host_ok),
        .reject  (rx_host_rej)
    );

    assign rx_wr_word = {rx_spi_data, {(DW-8){1'b0}}};

    mixw_byte_queue #(.DEPTH(DEPTH)) i_rx_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (flush),
        .wr_len  (rx_wr_len),
        .wr_word (rx_wr_word),
        .rd_len  (rx_rd_len),
        .peek    (rx_peek),
        .count   (rx_count)
    );

    // Return popped data only for a granted pop; byte pops land in bits 7:0.
    always_comb begin
        rx_full  = (rx_count == FULL_LVL);
        rx_empty = (rx_count == '0);
        if (!rx_host_ok) begin
            rx_host_data = '0;
        end else if (rx_host_wide) begin
            rx_host_data = rx_peek;
        end else begin
            rx_host_data = {{(DW-8){1'b0}}, rx_peek[DW-1 -: 8]};
        end
    end

    // Register one-cycle error pulses for refused host accesses.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            tx_err <= 1'b0;
            rx_err <= 1'b0;
        end else begin
            tx_err <= tx_host_rej;
            rx_err <= rx_host_rej;
        end
    end

    // Shifter-side refusals are silent by design; keep them observably used.
    logic unused_ok;
    assign unused_ok = ^{tx_host_ok, tx_spi_ok, tx_spi_rej, rx_spi_ok, rx_spi_rej};

endmodule

// File: rtl/mixw_spi_fifo_chk.sv
// Module: property checker for mixw_spi_fifo, attached by bind below.
// Observes ports only; assumes the same DEPTH as the design it watches.
module mixw_spi_fifo_chk #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             tx_host_push,
    input logic             tx_host_wide,
    input logic             tx_spi_pop,
    input logic [CNT_W-1:0] tx_free,
    input logic             tx_empty,
    input logic             tx_err,
    input logic             rx_spi_push,
    input logic             rx_host_pop,
    input logic [31:0]      rx_host_data,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_full,
    input logic             rx_empty,
    input logic             rx_err
);

    // R5
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_free <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH)));

    // R9
    tx_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && tx_host_push && !tx_host_wide && tx_free != '0
         && tx_spi_pop && !tx_empty) |=> $stable(tx_free));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_free == CNT_W'(DEPTH)) && rx_empty && !tx_err && !rx_err);

    // R6
    tx_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && tx_host_push && tx_host_wide && tx_free < CNT_W'(4)) |=> tx_err);

    // R8
    rx_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_host_pop && rx_empty) |-> (rx_host_data == 32'h0));

    // R11
    rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && rx_full && rx_spi_push && !rx_host_pop) |=> rx_full);

endmodule

bind mixw_spi_fifo mixw_spi_fifo_chk #(.DEPTH(DEPTH)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .tx_host_push (tx_host_push),
    .tx_host_wide (tx_host_wide),
    .tx_spi_pop   (tx_spi_pop),
    .tx_free      (tx_free),
    .tx_empty     (tx_empty),
    .tx_err       (tx_err),
    .rx_spi_push  (rx_spi_push),
    .rx_host_pop  (rx_host_pop),
    .rx_host_data (rx_host_data),
    .rx_count     (rx_count),
    .rx_full      (rx_full),
    .rx_empty     (rx_empty),
    .rx_err       (rx_err)
);

// File: tb/test_mixw_spi_fifo.sv
module test_mixw_spi_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        tx_host_push = 1'b0, tx_host_wide = 1'b0;
    logic [31:0] tx_host_data = '0;
    logic        tx_spi_pop = 1'b0;
    logic [7:0]  tx_spi_data;
    logic [5:0]  tx_free;
    logic        tx_full, tx_empty, tx_err;
    logic        rx_spi_push = 1'b0;
    logic [7:0]  rx_spi_data = '0;
    logic        rx_host_pop = 1'b0, rx_host_wide = 1'b0;
    logic [31:0] rx_host_data;
    logic [5:0]  rx_count;
    logic        rx_full, rx_empty, rx_err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mixw_spi_fifo i_mixw_spi_fifo (
        .clk, .rst_n, .flush,
        .tx_host_push, .tx_host_wide, .tx_host_data,
        .tx_spi_pop, .tx_spi_data, .tx_free, .tx_full, .tx_empty, .tx_err,
        .rx_spi_push, .rx_spi_data, .rx_host_pop, .rx_host_wide,
        .rx_host_data, .rx_count, .rx_full, .rx_empty, .rx_err
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one clock: inputs set at a negedge take effect at the next posedge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        flush = 0; tx_host_push = 0; tx_spi_pop = 0; rx_spi_push = 0; rx_host_pop = 0;
    endtask

    task automatic tx_push(input logic wide, input logic [31:0] d);
        tx_host_push = 1; tx_host_wide = wide; tx_host_data = d;
        cyc(); idle();
    endtask

    task automatic tx_take(output logic [7:0] b);
        tx_spi_pop = 1; #1 b = tx_spi_data;
        cyc(); idle();
    endtask

    task automatic rx_put(input logic [7:0] b);
        rx_spi_push = 1; rx_spi_data = b;
        cyc(); idle();
    endtask

    task automatic rx_take(input logic wide, output logic [31:0] d);
        rx_host_pop = 1; rx_host_wide = wide; #1 d = rx_host_data;
        cyc(); idle();
    endtask

    task automatic do_flush();
        flush = 1; cyc(); idle();
    endtask

    task automatic t_reset();
        chk("R1 tx_free", 32'(tx_free), 32);
        chk("R1 rx_count", 32'(rx_count), 0);
        chk("R1 flags", {tx_empty, rx_empty, tx_full, rx_full, tx_err, rx_err}, 6'b110000);
    endtask

    task automatic t_tx_order();
        logic [7:0] b;
        tx_push(1, 32'hA1B2C3D4);
        chk("R5 tx_free after word", 32'(tx_free), 28);
        tx_take(b); chk("R2 byte0", 32'(b), 32'hA1);
        tx_take(b); chk("R2 byte1", 32'(b), 32'hB2);
        tx_take(b); chk("R2 byte2", 32'(b), 32'hC3);
        tx_take(b); chk("R2 byte3", 32'(b), 32'hD4);
        chk("R5 tx_empty", {31'b0, tx_empty}, 1);
    endtask

    task automatic t_tx_byte();
        logic [7:0] b;
        tx_push(0, 32'hFFFFFF5E);
        chk("R3 tx_free", 32'(tx_free), 31);
        tx_take(b); chk("R3 byte", 32'(b), 32'h5E);
    endtask

    task automatic t_tx_fill();
        for (int i = 0; i < 7; i++) tx_push(1, 32'h01020304 + 32'(i));
        for (int i = 0; i < 3; i++) tx_push(0, 32'(8'h70 + i));
        chk("R5 tx_free 1", 32'(tx_free), 1);
        tx_push(1, 32'hDEADBEEF);
        chk("R6 word refused err", {31'b0, tx_err}, 1);
        chk("R6 word refused level", 32'(tx_free), 1);
        cyc();
        chk("R6 err one cycle", {31'b0, tx_err}, 0);
        tx_push(0, 32'h000000EE);
        chk("R5 tx_full", {30'b0, tx_full, tx_empty}, 2'b10);
        chk("R5 tx_free 0", 32'(tx_free), 0);
        tx_push(0, 32'h000000EF);
        chk("R6 byte refused err", {31'b0, tx_err}, 1);
        chk("R6 byte refused level", 32'(tx_free), 0);
        do_flush();
    endtask

    task automatic t_tx_simul();
        logic [7:0] b;
        tx_push(0, 32'h11); tx_push(0, 32'h22);
        tx_host_push = 1; tx_host_wide = 0; tx_host_data = 32'h33; tx_spi_pop = 1;
        #1 b = tx_spi_data;
        cyc(); idle();
        chk("R9 tx byte+pop data", 32'(b), 32'h11);
        chk("R9 tx byte+pop level", 32'(tx_free), 30);
        tx_host_push = 1; tx_host_wide = 1; tx_host_data = 32'h44556677; tx_spi_pop = 1;
        cyc(); idle();
        chk("R9 tx word+pop level", 32'(tx_free), 27);
        tx_take(b); chk("R9 tx order kept", 32'(b), 32'h33);
        tx_take(b); chk("R9 tx word head", 32'(b), 32'h44);
    endtask

    task automatic t_flush();
        rx_put(8'h5A);
        flush = 1; tx_host_push = 1; tx_host_wide = 0; tx_host_data = 32'h99;
        rx_spi_push = 1; rx_spi_data = 8'h66;
        cyc(); idle();
        chk("R10 tx_free", 32'(tx_free), 32);
        chk("R10 rx_count", 32'(rx_count), 0);
        chk("R10 errs", {30'b0, tx_err, rx_err}, 0);
        chk("R11 tx head zero when empty", 32'(tx_spi_data), 0);
    endtask

    task automatic t_rx_word();
        logic [31:0] d;
        rx_put(8'h11); rx_put(8'h22); rx_put(8'h33);
        chk("R5 rx_count 3", 32'(rx_count), 3);
        rx_take(1, d);
        chk("R7 refused data", d, 0);
        chk("R7 rx_err", {31'b0, rx_err}, 1);
        chk("R7 level kept", 32'(rx_count), 3);
        rx_put(8'h44);
        chk("R7 err cleared", {31'b0, rx_err}, 0);
        rx_take(1, d);
        chk("R4 word order", d, 32'h11223344);
        chk("R4 rx empty", {31'b0, rx_empty}, 1);
        rx_put(8'h9A);
        rx_take(0, d);
        chk("R4 byte pop", d, 32'h0000009A);
    endtask

    task automatic t_rx_empty();
        logic [31:0] d;
        rx_take(0, d);
        chk("R8 empty pop data", d, 0);
        chk("R8 level", 32'(rx_count), 0);
        chk("R8 no err", {31'b0, rx_err}, 0);
    endtask

    task automatic t_rx_full();
        logic [31:0] d;
        for (int i = 0; i < 32; i++) rx_put(8'(i + 1));
        chk("R5 rx_full", {30'b0, rx_full, rx_empty}, 2'b10);
        chk("R5 rx_count 32", 32'(rx_count), 32);
        rx_put(8'hFF);
        chk("R11 drop on full", 32'(rx_count), 32);
        rx_take(1, d);
        chk("R4 first word after fill", d, 32'h01020304);
        rx_spi_push = 1; rx_spi_data = 8'hAB; rx_host_pop = 1; rx_host_wide = 0;
        #1 d = rx_host_data;
        cyc(); idle();
        chk("R9 rx push+pop data", d, 32'h05);
        chk("R9 rx push+pop level", 32'(rx_count), 28);
        do_flush();
    endtask

    task automatic t_tx_empty_pop();
        logic [7:0] b;
        tx_take(b);
        chk("R11 empty pop data", 32'(b), 0);
        chk("R11 empty pop level", 32'(tx_free), 32);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_tx_order();
        t_tx_byte();
        t_tx_fill();
        t_tx_simul();
        t_flush();
        t_rx_word();
        t_rx_empty();
        t_rx_full();
        t_tx_empty_pop();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule